// File: doc/BRIEF.md
# Segment Limit Protection Checker

This block decides whether one memory access breaks the protection rules of the segment it goes through, before any paging step. Each access carries its linear address, a byte count, a kind (data read, data write or instruction fetch), and the state of the segment it targets: read and write permission, an expand-down flag, base and limit. It also carries three mode bits: protection enable, long mode active, and the code segment's 64-bit flag. The block returns the same address, a general-protection fault flag and a zero error code.

The checker sits in an access pipeline as one registered stage with valid/ready on both sides. The input is taken in a cycle where `in_valid` and `in_ready` are both high. The verdict shows on the output side on the next clock. While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` stays low. In a cycle where the output is taken, a new input can be taken at the same edge, so a full-rate stream has no bubbles.

The range rules cover expand-up and expand-down segments. Each of these also has a wrapped form, where the limit is smaller than the base. The end of an access is the address plus the size, computed one bit wider than the address so that a carry counts in every comparison.

Top module: `seg_guard`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An access taken in a cycle (`in_valid` and `in_ready` high at the edge) shows on the output with `out_valid` high after that same edge. `in_ready` equals `!out_valid || out_ready`.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_fault` keep their values.
- R4: With `prot_en` 0, no fault is ever raised, whatever the other fields hold.
- R5: With `prot_en` 1 and both `long_act` and `cs_long` 1, no fault is ever raised.
- R6: Checks apply when `prot_en` is 1 and not both long bits are 1. In that case a write (`kind` 2'b01) to a segment with `seg_wr_ok` 0 faults.
- R7: While checks apply, a data read (`kind` 2'b00 or 2'b11) from a segment with `seg_rd_ok` 0 faults. A fetch (`kind` 2'b10) is not subject to the read permission.
- R8: This rule covers expand-up (`seg_down` 0) with limit at or above base. The access faults when limit < addr+size.
- R9: This rule covers expand-up with limit below base. The access faults when limit < addr+size and addr < base.
- R10: This rule covers expand-down (`seg_down` 1) with limit at or above base. The access faults only when addr <= limit and addr+size >= base.
- R11: This rule covers expand-down with limit below base. The access faults when addr <= limit or addr+size >= base.
- R12: addr+size is computed with one extra bit. For example, address 0xFFFFFFF8 with size 8 gives 0x1_0000_0000, which lies above limit 0xFFFFFFFF.
- R13: `out_addr` equals the address of the access. `out_err` is zero for every result, including faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access offered |
| in_ready | output | 1 | Stage can take an access |
| in_addr | input | ADDR_W | Linear address of the access |
| in_size | input | SIZE_W | Byte count of the access |
| in_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| seg_rd_ok | input | 1 | Segment permits data reads |
| seg_wr_ok | input | 1 | Segment permits writes |
| seg_down | input | 1 | Segment grows downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| prot_en | input | 1 | Protected mode on |
| long_act | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is 64-bit |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_addr | output | ADDR_W | Address passed through |
| out_fault | output | 1 | General-protection fault |
| out_err | output | ERR_W | Fault error code, always zero |

## Verification
The only state is the output register and its valid bit. If one of them goes wrong, the fault bit or the address on the very next output beat is wrong. Under back-pressure, a held beat changes or a beat disappears. A wrong range decision has no state to hide in, so it shows one cycle after the input is taken. To make the boundaries come up often, random accesses are drawn in a small window around the base and the limit. Directed cases cover the exact equality points and the carry past the top of the address space.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_READ2 = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
    logic down;
  } seg_attr_t;
endpackage

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_chk_pkg::*;
(
  input  acc_kind_e kind,
  input  seg_attr_t attr,
  output logic      rights_fault
);
  logic is_write, is_read;
  always_comb begin
    is_write     = (kind == ACC_WRITE);
    is_read      = (kind == ACC_READ) || (kind == ACC_READ2);
    rights_fault = (is_write && !attr.wr_ok) || (is_read && !attr.rd_ok);
  end
endmodule

// File: rtl/seg_range_chk.sv
module seg_range_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              down,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              range_fault
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] end_x, base_x, lim_x, addr_x;
  logic wrapped, up_fault, down_fault;

  always_comb begin
    addr_x  = {1'b0, addr};
    base_x  = {1'b0, base};
    lim_x   = {1'b0, limit};
    end_x   = addr_x + {{(EXT_W-SIZE_W){1'b0}}, size};
    wrapped = lim_x < base_x;
    if (wrapped) begin
      up_fault   = (lim_x < end_x) && (addr_x < base_x);
      down_fault = (addr_x <= lim_x) || (end_x >= base_x);
    end else begin
      up_fault   = lim_x < end_x;
      down_fault = (addr_x <= lim_x) && (end_x >= base_x);
    end
    range_fault = down ? down_fault : up_fault;
  end
endmodule

// File: rtl/seg_out_reg.sv
module seg_out_reg #(
  parameter int DATA_W = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [1:0]        in_kind,
  input  logic              seg_rd_ok,
  input  logic              seg_wr_ok,
  input  logic              seg_down,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              prot_en,
  input  logic              long_act,
  input  logic              cs_long,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault,
  output logic [ERR_W-1:0]  out_err
);
  localparam int PAY_W = ADDR_W + 1;

  seg_attr_t        attr;
  acc_kind_e        kind;
  logic             rights_f, range_f, checks_on, fault_d;
  logic [PAY_W-1:0] pay_in, pay_out;

  always_comb begin
    attr      = '{rd_ok: seg_rd_ok, wr_ok: seg_wr_ok, down: seg_down};
    kind      = acc_kind_e'(in_kind);
    checks_on = prot_en && !(long_act && cs_long);
    fault_d   = checks_on && (rights_f || range_f);
    pay_in    = {fault_d, in_addr};
  end

  seg_rights_chk u_rights (
    .kind         (kind),
    .attr         (attr),
    .rights_fault (rights_f)
  );

  seg_range_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_range (
    .addr        (in_addr),
    .size        (in_size),
    .down        (seg_down),
    .base        (seg_base),
    .limit       (seg_limit),
    .range_fault (range_f)
  );

  seg_out_reg #(.DATA_W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_addr  = pay_out[ADDR_W-1:0];
  assign out_fault = pay_out[ADDR_W];
  assign out_err   = '0;
endmodule

// File: rtl/seg_guard_sva.sv
module seg_guard_sva #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_kind,
  input logic              seg_wr_ok,
  input logic              prot_en,
  input logic              long_act,
  input logic              cs_long,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_fault,
  input logic [ERR_W-1:0]  out_err
);
  logic take;
  assign take = in_valid && in_ready;

  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_take_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_fault)));

  p_real_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !prot_en) |=> !out_fault);

  p_long_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && long_act && cs_long) |=> !out_fault);

  p_write_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && prot_en && !(long_act && cs_long) && in_kind == 2'b01 && !seg_wr_ok)
      |=> out_fault);

  p_addr_pass_r13: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_addr == $past(in_addr)));

  p_err_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_err == '0));
endmodule

bind seg_guard seg_guard_sva #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ERR_W(ERR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .in_kind   (in_kind),
  .seg_wr_ok (seg_wr_ok),
  .prot_en   (prot_en),
  .long_act  (long_act),
  .cs_long   (cs_long),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_fault (out_fault),
  .out_err   (out_err)
);

// File: tb/seg_guard_test.sv
module seg_guard_test;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [SW-1:0] in_size = '0;
  logic [1:0]    in_kind = 2'b00;
  logic          seg_rd_ok = 1'b1, seg_wr_ok = 1'b1, seg_down = 1'b0;
  logic [AW-1:0] seg_base = '0, seg_limit = '1;
  logic          prot_en = 1'b0, long_act = 1'b0, cs_long = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic          out_fault;
  logic [EW-1:0] out_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_guard #(.ADDR_W(AW), .SIZE_W(SW), .ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_kind(in_kind),
    .seg_rd_ok(seg_rd_ok), .seg_wr_ok(seg_wr_ok), .seg_down(seg_down),
    .seg_base(seg_base), .seg_limit(seg_limit), .prot_en(prot_en),
    .long_act(long_act), .cs_long(cs_long), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_fault(out_fault),
    .out_err(out_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_fault(
    input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [1:0] k,
    input logic rd, input logic wr, input logic dn,
    input logic [AW-1:0] b, input logic [AW-1:0] l,
    input logic pe, input logic la, input logic cl);
    logic [AW:0] e, ax, bx, lx;
    logic perm, rng;
    if (!pe || (la && cl)) return 1'b0;
    ax = {1'b0, a}; bx = {1'b0, b}; lx = {1'b0, l};
    e  = ax + {{(AW+1-SW){1'b0}}, s};
    perm = (k == 2'b01 && !wr) || ((k == 2'b00 || k == 2'b11) && !rd);
    if (!dn) rng = (lx < bx) ? ((lx < e) && (ax < bx)) : (lx < e);
    else     rng = (lx < bx) ? ((ax <= lx) || (e >= bx)) : ((ax <= lx) && (e >= bx));
    return perm || rng;
  endfunction

  task automatic setup(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [1:0] k,
                       input logic rd, input logic wr, input logic dn,
                       input logic [AW-1:0] b, input logic [AW-1:0] l,
                       input logic pe, input logic la, input logic cl);
    in_addr = a; in_size = s; in_kind = k; seg_rd_ok = rd; seg_wr_ok = wr;
    seg_down = dn; seg_base = b; seg_limit = l; prot_en = pe; long_act = la; cs_long = cl;
  endtask

  task automatic send(input string req,
                      input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [1:0] k,
                      input logic rd, input logic wr, input logic dn,
                      input logic [AW-1:0] b, input logic [AW-1:0] l,
                      input logic pe, input logic la, input logic cl);
    logic ef;
    @(negedge clk);
    setup(a, s, k, rd, wr, dn, b, l, pe, la, cl);
    ef = model_fault(a, s, k, rd, wr, dn, b, l, pe, la, cl);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " fault"}, 64'(out_fault), 64'(ef));
    check("R13 addr", 64'(out_addr), 64'(a));
    if (out_fault) check("R13 err", 64'(out_err), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ha;
    logic          hf;
    void'($urandom(32'h1234_abcd));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R4: real mode ignores all rules
    send("R4", 32'h50, 4'd4, 2'b01, 0, 0, 0, 32'h100, 32'h10, 0, 0, 0);
    // R5: long mode bypass
    send("R5", 32'h50, 4'd4, 2'b01, 0, 0, 0, 32'h100, 32'h10, 1, 1, 1);
    send("R5 one bit only", 32'h50, 4'd4, 2'b01, 1, 0, 0, 32'h0, 32'hFFF, 1, 1, 0);
    // R6 write permission
    send("R6", 32'h20, 4'd2, 2'b01, 1, 0, 0, 32'h0, 32'hFFF, 1, 0, 0);
    send("R6 allowed", 32'h20, 4'd2, 2'b01, 1, 1, 0, 32'h0, 32'hFFF, 1, 0, 0);
    // R7 read permission, fetch exempt
    send("R7 read", 32'h20, 4'd2, 2'b00, 0, 1, 0, 32'h0, 32'hFFF, 1, 0, 0);
    send("R7 read2", 32'h20, 4'd2, 2'b11, 0, 1, 0, 32'h0, 32'hFFF, 1, 0, 0);
    send("R7 fetch", 32'h20, 4'd2, 2'b10, 0, 1, 0, 32'h0, 32'hFFF, 1, 0, 0);
    // R8 expand-up boundary
    send("R8 edge in", 32'hFC, 4'd4, 2'b00, 1, 1, 0, 32'h0, 32'h100, 1, 0, 0);
    send("R8 edge out", 32'hFD, 4'd4, 2'b00, 1, 1, 0, 32'h0, 32'h100, 1, 0, 0);
    // R9 expand-up wrapped
    send("R9 low", 32'h80, 4'd4, 2'b00, 1, 1, 0, 32'h200, 32'h100, 1, 0, 0);
    send("R9 between", 32'h180, 4'd4, 2'b00, 1, 1, 0, 32'h200, 32'h100, 1, 0, 0);
    send("R9 high", 32'h300, 4'd4, 2'b00, 1, 1, 0, 32'h200, 32'h100, 1, 0, 0);
    // R10 expand-down normal
    send("R10 inside", 32'h150, 4'd4, 2'b00, 1, 1, 1, 32'h100, 32'h200, 1, 0, 0);
    send("R10 above", 32'h250, 4'd4, 2'b00, 1, 1, 1, 32'h100, 32'h200, 1, 0, 0);
    // R11 expand-down wrapped
    send("R11 below lim", 32'h50, 4'd4, 2'b00, 1, 1, 1, 32'h200, 32'h100, 1, 0, 0);
    send("R11 gap", 32'h150, 4'd4, 2'b00, 1, 1, 1, 32'h200, 32'h100, 1, 0, 0);
    send("R11 reach base", 32'h1FC, 4'd4, 2'b00, 1, 1, 1, 32'h200, 32'h100, 1, 0, 0);
    // R12 carry past top
    send("R12 carry", 32'hFFFF_FFF8, 4'd8, 2'b00, 1, 1, 0, 32'h0, 32'hFFFF_FFFF, 1, 0, 0);
    check("R12 carry faults", 64'(out_fault), 64'd1);

    // R2/R3 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    setup(32'h44, 4'd4, 2'b01, 1, 0, 0, 32'h0, 32'hFFF, 1, 0, 0);
    in_valid = 1'b1;
    ha = 32'h44; hf = 1'b1;
    @(negedge clk);
    check("R2 shown", 64'(out_valid), 64'd1);
    check("R2 ready low", 64'(in_ready), 64'd0);
    setup(32'h88, 4'd4, 2'b00, 1, 1, 0, 32'h0, 32'hFFF, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 hold valid", 64'(out_valid), 64'd1);
      check("R3 hold addr", 64'(out_addr), 64'(ha));
      check("R3 hold fault", 64'(out_fault), 64'(hf));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 next addr", 64'(out_addr), 64'h88);
    check("R2 next fault", 64'(out_fault), 64'd0);
    @(negedge clk);
    check("R2 drained", 64'(out_valid), 64'd0);

    // random, small window so boundaries are hit
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ra, rb, rl;
      ra = AW'($urandom % 64);
      rb = AW'($urandom % 64);
      rl = AW'($urandom % 64);
      if (($urandom % 8) == 0) begin
        ra = ra | 32'hFFFF_FFC0; rl = rl | 32'hFFFF_FFC0;
      end
      send("R8-R11 random", ra, SW'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), rb, rl, ($urandom % 4) != 0, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule